// File: doc/BRIEF.md
# Sort-Filter-Concentrate Cell Front End

This block sits in front of a self-routing fabric and turns up to eight cell requests into a set that has no conflicts and no gaps. Each input offers a valid flag, a destination port number and a payload. A bitonic compare-exchange network sorts the cells by destination. A filter then keeps one cell from each group of cells that share a destination. A log-depth prefix adder gives each surviving cell its rank, and a concentrator writes every survivor to the output position equal to its rank.

The block returns an acknowledge to each input whose cell got through. A cell that is not acknowledged must be offered again by its source. The network is combinational and its outputs are registered, so the latency is one clock. The inputs sampled at a rising edge appear on the outputs right after that same edge.

Top module: `sfc_front_end`

## Requirements
- R1: While rst_ni is low, out_valid_o, out_dest_o, out_src_o, out_data_o and ack_o are all zero.
- R2: The outputs after a rising edge are a function of the inputs sampled at that edge. The latency is one cycle.
- R3: The number of valid output positions equals the number of distinct destinations among the valid inputs.
- R4: Valid output positions hold strictly increasing destinations, going from position 0 upward.
- R5: Valid outputs form a gap-free run at positions 0..M-1. Every position at M or above has valid, dest, src and data equal to zero.
- R6: When several valid inputs share a destination, the cell from the lowest-numbered input survives. out_src_o carries that input number.
- R7: At each valid position, out_data_o equals the payload of the input named by out_src_o.
- R8: ack_o[i] is 1 exactly when the cell of input i appears at some output. An input whose valid flag is low is never acknowledged.
- R9: The destination and payload of an input whose valid flag is low have no effect on any output.
- R10: Lane i uses bits [i*W +: W] of each packed bus, where W is the field width. The same rule applies to input index i and output position q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 8 | Request flag for each input |
| in_dest_i | input | 24 | Destination port of each input, 3 bits per lane |
| in_data_i | input | 128 | Payload of each input, 16 bits per lane |
| out_valid_o | output | 8 | Occupancy of each output position |
| out_dest_o | output | 24 | Destination at each output position |
| out_src_o | output | 24 | Input index that supplied each output position |
| out_data_o | output | 128 | Payload at each output position |
| ack_o | output | 8 | Acknowledge for each input |

## Verification
The bench recomputes every output from the request pattern in the same cycle and compares it with the design. Some internal faults do not show up as a crash or a hang. A compare element that orders or breaks ties the wrong way shows up in the next cycle as descending destinations or as the wrong surviving source. A wrong rank shows up as a hole in the occupied run or as two cells sharing one position. A lost source index gives wrong acknowledge bits. Each vector is checked one cycle after it is applied, so a fault is reported on the first pattern that triggers it.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  parameter int NUM_PORTS = 8;
  parameter int DEST_W    = 3;
  parameter int PAY_W     = 16;
  localparam int IDX_W    = $clog2(NUM_PORTS);
  localparam int LOG_N    = $clog2(NUM_PORTS);
  localparam int CNT_W    = IDX_W + 1;

  typedef struct packed {
    logic              vld;
    logic [DEST_W-1:0] dest;
    logic [IDX_W-1:0]  src;
    logic [PAY_W-1:0]  data;
  } cell_t;

  // invalid cells sort last; equal destinations tie-break on lower source
  function automatic logic [DEST_W+IDX_W:0] sort_key(cell_t c);
    return {~c.vld, c.dest, c.src};
  endfunction
endpackage

// File: rtl/sfc_cmp_swap.sv
module sfc_cmp_swap
  import sfc_pkg::*;
#(
  parameter bit ASCEND = 1'b1
) (
  input  cell_t a_i,
  input  cell_t b_i,
  output cell_t lo_o,
  output cell_t hi_o
);
  logic a_first;
  assign a_first = (sort_key(a_i) < sort_key(b_i)) == ASCEND;
  assign lo_o = a_first ? a_i : b_i;
  assign hi_o = a_first ? b_i : a_i;
endmodule

// File: rtl/sfc_bitonic_sorter.sv
module sfc_bitonic_sorter
  import sfc_pkg::*;
(
  input  cell_t cells_i [NUM_PORTS],
  output cell_t cells_o [NUM_PORTS]
);
  localparam int NUM_LAYERS = LOG_N * (LOG_N + 1) / 2;

  cell_t lay [NUM_LAYERS+1][NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_in
    assign lay[0][p] = cells_i[p];
    assign cells_o[p] = lay[NUM_LAYERS][p];
  end

  for (genvar s = 1; s <= LOG_N; s++) begin : g_blk
    for (genvar t = s - 1; t >= 0; t--) begin : g_step
      localparam int L    = s * (s - 1) / 2 + (s - 1 - t);
      localparam int DIST = 1 << t;
      localparam int SPAN = 1 << s;
      for (genvar i = 0; i < NUM_PORTS; i++) begin : g_el
        if ((i ^ DIST) > i) begin : g_cs
          sfc_cmp_swap #(.ASCEND((i & SPAN) == 0)) u_cs (
            .a_i (lay[L][i]),
            .b_i (lay[L][i^DIST]),
            .lo_o(lay[L+1][i]),
            .hi_o(lay[L+1][i^DIST])
          );
        end
      end
    end
  end
endmodule

// File: rtl/sfc_filter_rank.sv
module sfc_filter_rank
  import sfc_pkg::*;
(
  input  cell_t            sorted_i [NUM_PORTS],
  output logic [NUM_PORTS-1:0] keep_o,
  output logic [CNT_W-1:0] rank_o [NUM_PORTS]
);
  logic [CNT_W-1:0] psum [LOG_N+1][NUM_PORTS];

  // invalid cells are at the tail, so comparing with the left neighbour is enough
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_keep
    if (p == 0) begin : g_first
      assign keep_o[p] = sorted_i[p].vld;
    end else begin : g_rest
      assign keep_o[p] = sorted_i[p].vld &&
                         (!sorted_i[p-1].vld || sorted_i[p].dest != sorted_i[p-1].dest);
    end
    assign psum[0][p] = CNT_W'(keep_o[p]);
  end

  // log-depth inclusive prefix sum
  for (genvar s = 0; s < LOG_N; s++) begin : g_lvl
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
      if (p >= (1 << s)) begin : g_add
        assign psum[s+1][p] = psum[s][p] + psum[s][p-(1<<s)];
      end else begin : g_pass
        assign psum[s+1][p] = psum[s][p];
      end
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rank
    assign rank_o[p] = psum[LOG_N][p] - CNT_W'(keep_o[p]);
  end
endmodule

// File: rtl/sfc_concentrator.sv
module sfc_concentrator
  import sfc_pkg::*;
(
  input  cell_t                sorted_i [NUM_PORTS],
  input  logic [NUM_PORTS-1:0] keep_i,
  input  logic [CNT_W-1:0]     rank_i [NUM_PORTS],
  output cell_t                cells_o [NUM_PORTS],
  output logic [NUM_PORTS-1:0] ack_o
);
  for (genvar q = 0; q < NUM_PORTS; q++) begin : g_pos
    always_comb begin
      cells_o[q] = '0;
      for (int p = 0; p < NUM_PORTS; p++)
        if (keep_i[p] && rank_i[p] == CNT_W'(q)) cells_o[q] = sorted_i[p];
    end
  end

  always_comb begin
    ack_o = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (keep_i[p]) ack_o[sorted_i[p].src] = 1'b1;
  end
endmodule

// File: rtl/sfc_front_end.sv
module sfc_front_end
  import sfc_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_PORTS-1:0]        in_valid_i,
  input  logic [NUM_PORTS*DEST_W-1:0] in_dest_i,
  input  logic [NUM_PORTS*PAY_W-1:0]  in_data_i,
  output logic [NUM_PORTS-1:0]        out_valid_o,
  output logic [NUM_PORTS*DEST_W-1:0] out_dest_o,
  output logic [NUM_PORTS*IDX_W-1:0]  out_src_o,
  output logic [NUM_PORTS*PAY_W-1:0]  out_data_o,
  output logic [NUM_PORTS-1:0]        ack_o
);
  cell_t                in_cells  [NUM_PORTS];
  cell_t                srt_cells [NUM_PORTS];
  cell_t                con_cells [NUM_PORTS];
  logic [NUM_PORTS-1:0] keep;
  logic [CNT_W-1:0]     rank [NUM_PORTS];
  logic [NUM_PORTS-1:0] ack_d;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_unpack
    assign in_cells[i].vld  = in_valid_i[i];
    assign in_cells[i].dest = in_dest_i[i*DEST_W +: DEST_W];
    assign in_cells[i].src  = IDX_W'(i);
    assign in_cells[i].data = in_data_i[i*PAY_W +: PAY_W];
  end

  sfc_bitonic_sorter u_sort (.cells_i(in_cells), .cells_o(srt_cells));

  sfc_filter_rank u_filt (.sorted_i(srt_cells), .keep_o(keep), .rank_o(rank));

  sfc_concentrator u_conc (
    .sorted_i(srt_cells), .keep_i(keep), .rank_i(rank),
    .cells_o(con_cells), .ack_o(ack_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= '0;
      out_dest_o  <= '0;
      out_src_o   <= '0;
      out_data_o  <= '0;
      ack_o       <= '0;
    end else begin
      for (int q = 0; q < NUM_PORTS; q++) begin
        out_valid_o[q]                  <= con_cells[q].vld;
        out_dest_o[q*DEST_W +: DEST_W]  <= con_cells[q].dest;
        out_src_o[q*IDX_W +: IDX_W]     <= con_cells[q].src;
        out_data_o[q*PAY_W +: PAY_W]    <= con_cells[q].data;
      end
      ack_o <= ack_d;
    end
  end

  // R5
  gap_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o & (out_valid_o + 1'b1)) == '0);

  // R3
  ack_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ack_o) == $countones(out_valid_o));

  // R8
  ack_valid_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o & ~$past(in_valid_i)) == '0);

  for (genvar q = 0; q + 1 < NUM_PORTS; q++) begin : g_ord_chk
    // R4
    dest_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[q+1] |->
        out_dest_o[q*DEST_W +: DEST_W] < out_dest_o[(q+1)*DEST_W +: DEST_W]);
  end

  for (genvar q = 0; q < NUM_PORTS; q++) begin : g_src_chk
    // R8
    src_acked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[q] |-> ack_o[out_src_o[q*IDX_W +: IDX_W]]);
  end
endmodule

// File: tb/sfc_front_end_test.sv
`timescale 1ns/1ps
module sfc_front_end_test;
  localparam int N  = 8;
  localparam int DW = 3;
  localparam int IW = 3;
  localparam int PW = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N-1:0]      in_valid = '0;
  logic [N*DW-1:0]   in_dest = '0;
  logic [N*PW-1:0]   in_data = '0;
  logic [N-1:0]      out_valid;
  logic [N*DW-1:0]   out_dest;
  logic [N*IW-1:0]   out_src;
  logic [N*PW-1:0]   out_data;
  logic [N-1:0]      ack;

  logic [N-1:0]      e_valid;
  logic [N*DW-1:0]   e_dest;
  logic [N*IW-1:0]   e_src;
  logic [N*PW-1:0]   e_data;
  logic [N-1:0]      e_ack;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sfc_front_end uut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_dest_i(in_dest), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_dest_o(out_dest), .out_src_o(out_src),
    .out_data_o(out_data), .ack_o(ack)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference: walk destinations upward, lowest input index wins each
  task automatic model();
    int pos = 0;
    e_valid = '0; e_dest = '0; e_src = '0; e_data = '0; e_ack = '0;
    for (int d = 0; d < (1 << DW); d++) begin
      for (int i = 0; i < N; i++) begin
        if (in_valid[i] && in_dest[i*DW +: DW] == DW'(d)) begin
          e_valid[pos]          = 1'b1;
          e_dest[pos*DW +: DW]  = DW'(d);
          e_src[pos*IW +: IW]   = IW'(i);
          e_data[pos*PW +: PW]  = in_data[i*PW +: PW];
          e_ack[i]              = 1'b1;
          pos++;
          break;
        end
      end
    end
  endtask

  // R2: apply at negedge, output valid after next posedge
  task automatic apply_check();
    model();
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == e_valid, "R3/R5 valid", 128'(out_valid), 128'(e_valid));
    chk(out_dest  == e_dest,  "R4 dest",     128'(out_dest),  128'(e_dest));
    chk(out_src   == e_src,   "R6 src",      128'(out_src),   128'(e_src));
    chk(out_data  == e_data,  "R7 data",     128'(out_data),  128'(e_data));
    chk(ack       == e_ack,   "R8 ack",      128'(ack),       128'(e_ack));
  endtask

  task automatic set_lane(input int i, input bit v, input int d, input int p);
    in_valid[i]        = v;
    in_dest[i*DW +: DW] = DW'(d);
    in_data[i*PW +: PW] = PW'(p);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] keep_v;
    logic [N*DW-1:0] sv_dest;
    logic [N*PW-1:0] sv_data;
    void'($urandom(32'h1d3c_5a71));
    in_valid = '1;
    in_dest  = '1;
    in_data  = '1;
    repeat (3) @(negedge clk);
    // R1
    chk(out_valid == '0 && out_dest == '0 && out_src == '0 && out_data == '0 && ack == '0,
        "R1 reset", 128'({out_valid, ack}), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // R5 all idle
    in_valid = '0;
    apply_check();
    // R6 all same destination
    for (int i = 0; i < N; i++) set_lane(i, 1'b1, 5, 16'h100 + i);
    apply_check();
    // R6 same destination, lowest valid input is 3
    in_valid = 8'b1111_1000;
    apply_check();
    // R4 full reversed permutation
    for (int i = 0; i < N; i++) set_lane(i, 1'b1, N - 1 - i, 16'hA000 + i);
    apply_check();
    // R10 single request on top lane
    in_valid = '0;
    set_lane(7, 1'b1, 0, 16'hBEEF);
    apply_check();
    // R3 pairs of duplicates
    for (int i = 0; i < N; i++) set_lane(i, 1'b1, (i / 2) * 2, 16'h3000 + i);
    apply_check();

    // R9 invalid lanes' dest/data must not matter
    for (int i = 0; i < N; i++) set_lane(i, 1'b1, 7 - (i % 4), 16'h5000 + i);
    in_valid = 8'b0101_0110;
    apply_check();
    sv_dest = out_dest; sv_data = out_data; keep_v = out_valid;
    for (int i = 0; i < N; i++)
      if (!in_valid[i]) begin
        in_dest[i*DW +: DW] = 3'd0;
        in_data[i*PW +: PW] = 16'hDEAD;
      end
    apply_check();
    chk(out_valid == keep_v && out_dest == sv_dest && out_data == sv_data,
        "R9 invalid ignored", 128'(out_dest), 128'(sv_dest));

    // random mix
    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < N; i++)
        set_lane(i, ($urandom % 4) != 0, $urandom % (1 << DW), $urandom % 65536);
      if (n % 7 == 0) in_valid = N'($urandom);
      apply_check();
    end

    // R1 asynchronous reset in mid-run
    #1 rst_n = 1'b0;
    #1;
    chk(out_valid == '0 && ack == '0 && out_data == '0, "R1 async reset",
        128'({out_valid, ack}), 128'(0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule